// File: doc/BRIEF.md
# Cache Range Maintenance Sequencer

This block takes one cache maintenance request at a time and turns it into a series of commands for a second-level cache. A request names an operation (invalidate, clean or flush), a first byte address, an exclusive last address and a write-through override flag. The sequencer trims the request to 32-byte lines. It emits single-line clean-and-invalidate commands for partial edge lines of an invalidate. It then cuts the full lines into chunks and sends each chunk as an inclusive start/end pair.

Each command is offered with valid/ready. The next command is not offered until the cache reports the previous one complete on `cmd_ack`. Once the last command has completed, the block raises a barrier request. When the barrier is acknowledged it pulses `done` and accepts the next request.

A chunk never holds more than a fixed number of bytes and never crosses a page. This keeps each stall of the cache bounded and lets the cache translate only the start address of a command.

Top module: `cache_range_seq`

## Requirements
- R1: After reset, and after a reset applied in the middle of a request, `req_ready` is 1 and `cmd_valid`, `barrier_req` and `done` are 0.
- R2: `cmd_kind` is one-hot: 3'b001 is a single-line clean-and-invalidate, 3'b010 a range clean and 3'b100 a range invalidate. While `cmd_valid` is high and `cmd_ready` is low, the kind and both addresses hold steady. No further command is offered until `cmd_ack` has been seen for the accepted one.
- R3: For clean and flush, the start is rounded down and the exclusive end rounded up to a 32-byte line before chunking. Every command address has its low five bits at zero.
- R4: For invalidate, an unaligned start first produces a line command on the line holding it, and the start then moves up to the next line. An unaligned end then produces a line command on its own line, and the end moves down to that line. A line command carries the same address in `cmd_lo` and `cmd_hi`.
- R5: A chunk starting at S ends (exclusively) at the least of three values: the aligned end, S+1024, and the next 4096-byte page boundary (S OR 4095)+1. The chunk is sent with `cmd_lo`=S and `cmd_hi`=end-32, so both addresses lie in one page.
- R6: For flush, each chunk produces a range clean followed by a range invalidate on the same addresses. The next chunk begins only after both have completed.
- R7: With the write-through flag set, a clean request issues no commands, and a flush issues only its range invalidates. An invalidate is unaffected by the flag.
- R8: When the aligned start is not below the aligned end, no range command is issued. The line commands of R4 are still issued.
- R9: After the last command completes, `barrier_req` stays high until `barrier_ack`. `done` is high for exactly the one cycle after the acknowledge edge, and `req_ready` returns in the cycle after that.
- R10: `req_op` encoding: 2'b00 invalidate, 2'b01 clean, 2'b10 and 2'b11 flush. A request is taken only while `req_ready` is high, and `req_ready` stays low while a request is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken on valid |
| req_op | input | 2 | Operation code (R10) |
| req_wt | input | 1 | Write-through override |
| req_start | input | AW | First byte address |
| req_end | input | AW | Exclusive end address |
| cmd_valid | output | 1 | Command offered to cache |
| cmd_ready | input | 1 | Cache accepts command |
| cmd_kind | output | 3 | One-hot command kind (R2) |
| cmd_lo | output | AW | Inclusive first line address |
| cmd_hi | output | AW | Inclusive last line address |
| cmd_ack | input | 1 | Cache reports command complete |
| barrier_req | output | 1 | Barrier requested |
| barrier_ack | input | 1 | Barrier complete |
| done | output | 1 | One-cycle end-of-request pulse |

## Verification
The size cap and the page boundary can end the same chunk at the same address. A start of 0xC00 makes both limits fall on 0x1000. The bench checks that exactly one chunk ends there and that no empty chunk follows. The head and tail edge lines of an invalidate can also be the same line, as with 0x105 to 0x10A. That case must give two line commands on 0x100 and no range command. Both cases are judged against a sequence computed in the bench from the requirements, with the ready and acknowledge delays varied for each request.

// File: rtl/crs_pkg.sv
package crs_pkg;

    typedef enum logic [1:0] {
        OP_INV       = 2'b00,
        OP_CLEAN     = 2'b01,
        OP_FLUSH     = 2'b10,
        OP_FLUSH_ALT = 2'b11
    } crs_op_e;

    localparam logic [2:0] KIND_LINE_CI     = 3'b001;
    localparam logic [2:0] KIND_RANGE_CLEAN = 3'b010;
    localparam logic [2:0] KIND_RANGE_INV   = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_BAR,
        ST_DONE
    } crs_state_e;

    typedef enum logic [1:0] {
        STEP_HEAD,
        STEP_TAIL,
        STEP_CLEAN,
        STEP_INV
    } crs_step_e;

endpackage

// File: rtl/crs_align.sv
module crs_align
    import crs_pkg::*;
#(
    parameter int AW         = 32,
    parameter int LINE_BYTES = 32
) (
    input  crs_op_e         op,
    input  logic [AW-1:0]   start_addr,
    input  logic [AW-1:0]   end_addr,
    output logic [AW:0]     start_al,
    output logic [AW:0]     end_al,
    output logic            head_need,
    output logic            tail_need,
    output logic [AW-1:0]   head_line,
    output logic [AW-1:0]   tail_line
);
    localparam int          LB       = $clog2(LINE_BYTES);
    localparam logic [AW:0] LMASK    = (AW+1)'(LINE_BYTES - 1);
    localparam logic [AW-1:0] LMASK_N = AW'(LINE_BYTES - 1);

    logic [AW:0] s_ext;
    logic [AW:0] e_ext;

    always_comb begin
        s_ext     = {1'b0, start_addr};
        e_ext     = {1'b0, end_addr};
        head_line = start_addr & ~LMASK_N;
        tail_line = end_addr & ~LMASK_N;
        if (op == OP_INV) begin
            // r4_: partial edges get a line command, the range shrinks inward
            head_need = |start_addr[LB-1:0];
            tail_need = |end_addr[LB-1:0];
            start_al  = head_need ? ((s_ext | LMASK) + 1'b1) : s_ext;
            end_al    = e_ext & ~LMASK;
        end else begin
            // r3_: clean and flush grow outward to whole lines
            head_need = 1'b0;
            tail_need = 1'b0;
            start_al  = s_ext & ~LMASK;
            end_al    = (e_ext + LMASK) & ~LMASK;
        end
    end

endmodule

// File: rtl/crs_chunk.sv
module crs_chunk #(
    parameter int AW              = 32,
    parameter int PAGE_BYTES      = 4096,
    parameter int MAX_CHUNK_BYTES = 1024
) (
    input  logic [AW:0] cur,
    input  logic [AW:0] lim,
    output logic [AW:0] chunk_end
);
    localparam logic [AW:0] CAP   = (AW+1)'(MAX_CHUNK_BYTES);
    localparam logic [AW:0] PMASK = (AW+1)'(PAGE_BYTES - 1);

    logic [AW:0] cap_end;
    logic [AW:0] page_end;

    // r5_: least of request end, size cap and next page boundary
    always_comb begin
        cap_end   = cur + CAP;
        page_end  = (cur | PMASK) + 1'b1;
        chunk_end = lim;
        if (cap_end < chunk_end)  chunk_end = cap_end;
        if (page_end < chunk_end) chunk_end = page_end;
    end

endmodule

// File: rtl/cache_range_seq.sv
module cache_range_seq
    import crs_pkg::*;
#(
    parameter int AW              = 32,
    parameter int LINE_BYTES      = 32,
    parameter int PAGE_BYTES      = 4096,
    parameter int MAX_CHUNK_BYTES = 1024
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [1:0]    req_op,
    input  logic          req_wt,
    input  logic [AW-1:0] req_start,
    input  logic [AW-1:0] req_end,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [2:0]    cmd_kind,
    output logic [AW-1:0] cmd_lo,
    output logic [AW-1:0] cmd_hi,
    input  logic          cmd_ack,
    output logic          barrier_req,
    input  logic          barrier_ack,
    output logic          done
);
    localparam int            LB       = $clog2(LINE_BYTES);
    localparam int            PB       = $clog2(PAGE_BYTES);
    localparam logic [AW-1:0] LINE_AW  = AW'(LINE_BYTES);
    localparam logic [AW-1:0] SPAN_MAX = AW'(MAX_CHUNK_BYTES - LINE_BYTES);

    typedef struct packed {
        crs_state_e    state;
        crs_step_e     step;
        crs_op_e       op;
        logic          wt;
        logic [AW:0]   cur;
        logic [AW:0]   lim;
        logic          tail_need;
        logic [AW-1:0] head_line;
        logic [AW-1:0] tail_line;
    } regs_t;

    regs_t q, d;

    // request alignment
    crs_op_e       in_op;
    logic [AW:0]   al_start, al_end;
    logic          al_head, al_tail;
    logic [AW-1:0] al_hline, al_tline;

    assign in_op = crs_op_e'(req_op);

    crs_align #(.AW(AW), .LINE_BYTES(LINE_BYTES)) u_align (
        .op        (in_op),
        .start_addr(req_start),
        .end_addr  (req_end),
        .start_al  (al_start),
        .end_al    (al_end),
        .head_need (al_head),
        .tail_need (al_tail),
        .head_line (al_hline),
        .tail_line (al_tline)
    );

    // chunk boundary for the current position
    logic [AW:0] chunk_end;

    crs_chunk #(.AW(AW), .PAGE_BYTES(PAGE_BYTES), .MAX_CHUNK_BYTES(MAX_CHUNK_BYTES)) u_chunk (
        .cur      (q.cur),
        .lim      (q.lim),
        .chunk_end(chunk_end)
    );

    // entry into the chunk loop: from a new request or after a step finishes
    crs_op_e     ent_op;
    logic        ent_wt;
    logic [AW:0] ent_cur;
    logic [AW:0] ent_lim;
    logic        ent_bar;
    crs_step_e   ent_step;

    always_comb begin
        if (q.state == ST_IDLE) begin
            ent_op  = in_op;
            ent_wt  = req_wt;
            ent_cur = al_start;
            ent_lim = al_end;
        end else begin
            ent_op  = q.op;
            ent_wt  = q.wt;
            ent_cur = (q.step == STEP_CLEAN || q.step == STEP_INV) ? chunk_end : q.cur;
            ent_lim = q.lim;
        end
        // r8_ / r7_: empty range or write-through clean goes straight to the barrier
        ent_bar  = (ent_cur >= ent_lim) || (ent_op == OP_CLEAN && ent_wt);
        ent_step = (ent_op != OP_INV && !ent_wt) ? STEP_CLEAN : STEP_INV;
    end

    // next-state logic
    always_comb begin
        d = q;
        case (q.state)
            ST_IDLE: begin
                if (req_valid) begin
                    d.op        = in_op;
                    d.wt        = req_wt;
                    d.cur       = al_start;
                    d.lim       = al_end;
                    d.tail_need = al_tail;
                    d.head_line = al_hline;
                    d.tail_line = al_tline;
                    if (al_head) begin
                        d.state = ST_ISSUE;
                        d.step  = STEP_HEAD;
                    end else if (al_tail) begin
                        d.state = ST_ISSUE;
                        d.step  = STEP_TAIL;
                    end else begin
                        d.state = ent_bar ? ST_BAR : ST_ISSUE;
                        d.step  = ent_step;
                    end
                end
            end
            ST_ISSUE: begin
                if (cmd_ready) d.state = ST_WAIT;
            end
            ST_WAIT: begin
                if (cmd_ack) begin
                    case (q.step)
                        STEP_HEAD: begin
                            if (q.tail_need) begin
                                d.state = ST_ISSUE;
                                d.step  = STEP_TAIL;
                            end else begin
                                d.state = ent_bar ? ST_BAR : ST_ISSUE;
                                d.step  = ent_step;
                            end
                        end
                        STEP_TAIL: begin
                            d.state = ent_bar ? ST_BAR : ST_ISSUE;
                            d.step  = ent_step;
                        end
                        STEP_CLEAN: begin
                            if (q.op == OP_FLUSH || q.op == OP_FLUSH_ALT) begin
                                // r6_: same chunk, now the invalidate half
                                d.state = ST_ISSUE;
                                d.step  = STEP_INV;
                            end else begin
                                d.cur   = chunk_end;
                                d.state = ent_bar ? ST_BAR : ST_ISSUE;
                                d.step  = ent_step;
                            end
                        end
                        default: begin
                            d.cur   = chunk_end;
                            d.state = ent_bar ? ST_BAR : ST_ISSUE;
                            d.step  = ent_step;
                        end
                    endcase
                end
            end
            ST_BAR: begin
                if (barrier_ack) d.state = ST_DONE;
            end
            default: begin
                d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.step  <= STEP_HEAD;
            q.op    <= OP_INV;
        end else begin
            q <= d;
        end
    end

    // outputs
    always_comb begin
        req_ready   = (q.state == ST_IDLE);
        cmd_valid   = (q.state == ST_ISSUE);
        barrier_req = (q.state == ST_BAR);
        done        = (q.state == ST_DONE);
        case (q.step)
            STEP_HEAD: begin
                cmd_kind = KIND_LINE_CI;
                cmd_lo   = q.head_line;
                cmd_hi   = q.head_line;
            end
            STEP_TAIL: begin
                cmd_kind = KIND_LINE_CI;
                cmd_lo   = q.tail_line;
                cmd_hi   = q.tail_line;
            end
            STEP_CLEAN: begin
                cmd_kind = KIND_RANGE_CLEAN;
                cmd_lo   = q.cur[AW-1:0];
                cmd_hi   = chunk_end[AW-1:0] - LINE_AW;
            end
            default: begin
                cmd_kind = KIND_RANGE_INV;
                cmd_lo   = q.cur[AW-1:0];
                cmd_hi   = chunk_end[AW-1:0] - LINE_AW;
            end
        endcase
    end

    // assertions
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!cmd_valid && !barrier_req && !done));

    a_r2_kind_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> ($countones(cmd_kind) == 1));

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_kind) && $stable(cmd_lo) && $stable(cmd_hi)));

    a_r2_wait_for_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_valid);

    a_r3_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_lo[LB-1:0] == '0 && cmd_hi[LB-1:0] == '0));

    a_r5_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_lo[AW-1:PB] == cmd_hi[AW-1:PB]));

    a_r5_span_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> (cmd_hi >= cmd_lo && (cmd_hi - cmd_lo) <= SPAN_MAX));

    a_r7_wt_no_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && q.wt) |-> (cmd_kind != KIND_RANGE_CLEAN));

    a_r9_done_after_barrier: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(barrier_req && barrier_ack));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));

endmodule

// File: tb/tb_cache_range_seq.sv
module tb_cache_range_seq;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [1:0]    req_op = 2'b00;
    logic          req_wt = 1'b0;
    logic [AW-1:0] req_start = '0;
    logic [AW-1:0] req_end = '0;
    logic          cmd_valid;
    logic          cmd_ready = 1'b0;
    logic [2:0]    cmd_kind;
    logic [AW-1:0] cmd_lo, cmd_hi;
    logic          cmd_ack = 1'b0;
    logic          barrier_req;
    logic          barrier_ack = 1'b0;
    logic          done;

    always #4 clk = ~clk;   // 125 MHz

    cache_range_seq #(.AW(AW)) dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_wt(req_wt),
        .req_start(req_start), .req_end(req_end),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_kind(cmd_kind),
        .cmd_lo(cmd_lo), .cmd_hi(cmd_hi), .cmd_ack(cmd_ack),
        .barrier_req(barrier_req), .barrier_ack(barrier_ack), .done(done)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // expected and observed command lists
    logic [2:0]  exp_k [32];
    longint      exp_lo [32];
    longint      exp_hi [32];
    int          exp_n;
    logic [2:0]  got_k [32];
    longint      got_lo [32];
    longint      got_hi [32];
    int          got_n;

    task automatic push_exp(input logic [2:0] k, input longint lo, input longint hi);
        if (exp_n < 32) begin
            exp_k[exp_n] = k; exp_lo[exp_n] = lo; exp_hi[exp_n] = hi;
        end
        exp_n++;
    endtask

    // model built from R3..R8, R10
    task automatic build_exp(input logic [1:0] op, input bit wt, input longint s, input longint e);
        longint s2, e2, ce;
        exp_n = 0;
        if (op == 2'b00) begin
            if (s % 32 != 0) begin
                push_exp(3'b001, s - (s % 32), s - (s % 32));
                s2 = s - (s % 32) + 32;
            end else s2 = s;
            if (e % 32 != 0) push_exp(3'b001, e - (e % 32), e - (e % 32));
            e2 = e - (e % 32);
        end else begin
            s2 = s - (s % 32);
            e2 = ((e + 31) / 32) * 32;
        end
        if (!(op == 2'b01 && wt)) begin
            while (s2 < e2) begin
                ce = e2;
                if (s2 + 1024 < ce) ce = s2 + 1024;
                if ((s2 / 4096) * 4096 + 4096 < ce) ce = (s2 / 4096) * 4096 + 4096;
                if (op != 2'b00 && !wt) push_exp(3'b010, s2, ce - 32);
                if (op != 2'b01) push_exp(3'b100, s2, ce - 32);
                s2 = ce;
            end
        end
    endtask

    // drive one request and serve the cache side
    task automatic run_req(input logic [1:0] op, input bit wt, input logic [AW-1:0] s,
                           input logic [AW-1:0] e, input int rdly, input int adly);
        int guard;
        logic [2:0] k0;
        logic [AW-1:0] l0, h0;
        got_n = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10", "ready before request", req_ready, 1);
        req_valid = 1'b1; req_op = op; req_wt = wt; req_start = s; req_end = e;
        @(negedge clk);
        req_valid = 1'b0;
        guard = 0;
        while (1) begin
            if (guard > 4000) begin
                chk(1'b0, "R9", "request never finished", guard, 0);
                break;
            end
            if (barrier_req) begin
                chk(done == 1'b0, "R9", "done before barrier ack", done, 0);
                barrier_ack = 1'b1;
                @(negedge clk);
                barrier_ack = 1'b0;
                chk(done == 1'b1, "R9", "done after barrier ack", done, 1);
                chk(req_ready == 1'b0, "R10", "busy during done", req_ready, 0);
                @(negedge clk);
                chk(done == 1'b0, "R9", "done lasts one cycle", done, 0);
                chk(req_ready == 1'b1, "R9", "ready after done", req_ready, 1);
                break;
            end
            if (cmd_valid) begin
                chk(req_ready == 1'b0, "R10", "ready low while busy", req_ready, 0);
                k0 = cmd_kind; l0 = cmd_lo; h0 = cmd_hi;
                for (int r = 0; r < rdly; r++) begin
                    @(negedge clk);
                    chk(cmd_valid && cmd_kind == k0 && cmd_lo == l0 && cmd_hi == h0,
                        "R2", "command held while not ready", {cmd_lo, 1'b0, cmd_valid}, {l0, 1'b1});
                end
                cmd_ready = 1'b1;
                @(negedge clk);
                cmd_ready = 1'b0;
                chk(cmd_valid == 1'b0, "R2", "no command before ack", cmd_valid, 0);
                for (int a = 0; a < adly; a++) begin
                    @(negedge clk);
                    chk(cmd_valid == 1'b0, "R2", "waiting for ack", cmd_valid, 0);
                end
                if (got_n < 32) begin
                    got_k[got_n] = k0; got_lo[got_n] = l0; got_hi[got_n] = h0;
                end
                got_n++;
                cmd_ack = 1'b1;
                @(negedge clk);
                cmd_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
            guard++;
        end
    endtask

    task automatic compare(input string req);
        chk(got_n == exp_n, req, "command count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 32; i++) begin
            chk(got_k[i] == exp_k[i], req, $sformatf("kind of command %0d", i), got_k[i], exp_k[i]);
            chk(got_lo[i] == exp_lo[i], req, $sformatf("lo of command %0d", i), got_lo[i], exp_lo[i]);
            chk(got_hi[i] == exp_hi[i], req, $sformatf("hi of command %0d", i), got_hi[i], exp_hi[i]);
        end
    endtask

    // {op, wt, start, end}
    localparam int NV = 10;
    localparam logic [66:0] VECS [NV] = '{
        {2'b00, 1'b0, 32'h0000_1000, 32'h0000_1400},  // R5 aligned invalidate, one chunk
        {2'b01, 1'b0, 32'h0000_2005, 32'h0000_2811},  // R3 clean rounded outward
        {2'b10, 1'b0, 32'h0000_0F00, 32'h0000_1100},  // R6 flush across page
        {2'b00, 1'b0, 32'h0000_3004, 32'h0000_3050},  // R4 both edges partial
        {2'b01, 1'b1, 32'h0000_4000, 32'h0000_4400},  // R7 write-through clean
        {2'b10, 1'b1, 32'h0000_0500, 32'h0000_0540},  // R7 write-through flush
        {2'b00, 1'b0, 32'h0000_0105, 32'h0000_010A},  // R8 edges in one line
        {2'b01, 1'b0, 32'h0000_0800, 32'h0000_0800},  // R8 empty clean
        {2'b00, 1'b0, 32'h0000_0C00, 32'h0000_2000},  // R5 cap and page coincide
        {2'b11, 1'b0, 32'h0000_0040, 32'h0000_0060}   // R10 alternate flush code
    };

    function automatic string vec_tag(input int i);
        case (i)
            0: return "R5";
            1: return "R3";
            2: return "R6";
            3: return "R4";
            4: return "R7";
            5: return "R7";
            6: return "R8";
            7: return "R8";
            8: return "R5";
            default: return "R10";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "R9", "watchdog expired", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1", "cmd_valid in reset", cmd_valid, 0);
        chk(barrier_req == 1'b0, "R1", "barrier_req in reset", barrier_req, 0);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && !cmd_valid, "R1", "idle after reset", req_ready, 1);

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic        wt;
            logic [31:0] s, e;
            {op, wt, s, e} = VECS[i];
            build_exp(op, wt, longint'(s), longint'(e));
            run_req(op, wt, s, e, i % 3, (i % 2) + 1);
            compare(vec_tag(i));
        end

        // R2: long ready stall keeps the command steady
        build_exp(2'b10, 1'b0, 64'h1FC0, 64'h2040);
        run_req(2'b10, 1'b0, 32'h1FC0, 32'h2040, 5, 3);
        compare("R2");

        // R1: reset in the middle of a long request
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'b00; req_wt = 1'b0;
        req_start = 32'h0; req_end = 32'h8000;
        @(negedge clk);
        req_valid = 1'b0;
        chk(cmd_valid == 1'b1, "R1", "command offered before reset", cmd_valid, 1);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after mid reset", req_ready, 1);
        chk(cmd_valid == 1'b0, "R1", "no command after mid reset", cmd_valid, 0);
        chk(barrier_req == 1'b0 && done == 1'b0, "R1", "no barrier after mid reset", barrier_req, 0);

        // recovery after reset
        build_exp(2'b00, 1'b0, 64'h0020, 64'h0040);
        run_req(2'b00, 1'b0, 32'h0020, 32'h0040, 0, 0);
        compare("R1");

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule